// File: doc/BRIEF.md
# Timed LED Pattern Sequencer

This block drives a 16-bit LED bank through four fixed display groups, one after another. Every display step is held for a fixed interval counted out from the system clock. A prescaler counts clock cycles and raises a one-cycle step tick on its terminal count. With the default divide value at 100 MHz the interval is 500 ms. No delay construct of any kind is involved; the testbench shrinks the divide value to a few cycles.

A state machine holds the active group. Its four states are `GRP_BLINK` (group 0), `GRP_SWAP` (group 1), `GRP_PAIR` (group 2) and `GRP_CHASE` (group 3). Inside each state a step counter walks the group's patterns on each tick, and a pass counter counts complete walks through the group. When the last step of the last pass receives a tick, the machine takes its only transition. That transition goes to the next state: `GRP_BLINK`→`GRP_SWAP`→`GRP_PAIR`→`GRP_CHASE`→`GRP_BLINK`. The step and pass counters return to zero at the same moment. The index of the active group is driven on its own output.

Top module: `led_pattern_seq`

## Requirements
- R1: While `rst` is high and for the first CLKS_PER_STEP cycles after it falls, `led_out` is 0x0001 and `mode_out` is 0.
- R2: `led_out` changes only on the clock edge that follows a step tick, so each pattern is held for exactly CLKS_PER_STEP cycles.
- R3: In group 0 (`mode_out` = 0) the LEDs alternate 0x0001, 0x0002, starting with 0x0001.
- R4: In group 1 (`mode_out` = 1) the LEDs alternate 0xFF00, 0x00FF, starting with 0xFF00.
- R5: In group 2 (`mode_out` = 2) the LEDs alternate 0x3005, 0x01C6, starting with 0x3005.
- R6: In group 3 (`mode_out` = 3) the LEDs show 16 steps in this order: 0x0307, 0x0008, 0x1208, 0x0008, 0x4307, 0x0008, 0x2208, 0x8008, 0x1307, 0x0008, 0x3208, 0x0008, 0x4F07, 0x0788, 0x2208, 0x8388.
- R7: Each group is played for PASSES (default 11) complete passes, and then `mode_out` increases by one. `mode_out` changes at no other time.
- R8: After the last pass of group 3, `mode_out` wraps to 0 and `led_out` shows 0x0001.
- R9: Raising `rst` in the middle of a run returns the block to the R1 state on the next clock edge.
- R10: The step index never leaves the active group: group 3 restarts at 0x0307 after 0x8388, and each two-step group restarts at its first pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| led_out | output | 16 | Current LED pattern |
| mode_out | output | 2 | Index of the active pattern group (0 to 3) |

## Verification
The bench checks the exact edge on which the first step change happens after reset. A prescaler that is off by one would move 0x0002 a cycle early or late. It plays every step of every pass of all four groups through to the wrap back to group 0. This catches a pass counter that stops at 10 or 12 passes and a group 3 step order with swapped entries. It also catches a mode counter that does not wrap. A reset in the middle of group 1 must restore 0x0001 and mode 0 on the next edge, and a full step interval must then pass before anything changes. A design that kept the old prescaler value would advance early.

// File: rtl/led_seq_pkg.sv
package led_seq_pkg;

    localparam int unsigned LED_W  = 16;
    localparam int unsigned STEP_W = 4;

    typedef enum logic [1:0] {
        GRP_BLINK = 2'd0,
        GRP_SWAP  = 2'd1,
        GRP_PAIR  = 2'd2,
        GRP_CHASE = 2'd3
    } grp_e;

    // Number of steps in one pass of each group.
    function automatic logic [STEP_W:0] group_len(input grp_e g);
        logic [STEP_W:0] len;
        unique case (g)
            GRP_BLINK: len = 5'd2;
            GRP_SWAP:  len = 5'd2;
            GRP_PAIR:  len = 5'd2;
            GRP_CHASE: len = 5'd16;
            default:   len = 5'd2;
        endcase
        return len;
    endfunction

endpackage

// File: rtl/led_step_timer.sv
module led_step_timer #(
    parameter int unsigned CLKS_PER_STEP = 50_000_000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned CW = (CLKS_PER_STEP > 1) ? $clog2(CLKS_PER_STEP) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_STEP - 1);

    logic [CW-1:0] cnt;

    // terminal-count decoder
    assign tick = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/led_seq_fsm.sv
module led_seq_fsm
    import led_seq_pkg::*;
#(
    parameter int unsigned PASSES = 11,
    parameter int unsigned PASS_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    output grp_e              grp,
    output logic [STEP_W-1:0] step,
    output logic [PASS_W-1:0] pass
);
    grp_e              grp_n;
    logic [STEP_W-1:0] step_n;
    logic [PASS_W-1:0] pass_n;
    logic              last_step;
    logic              last_pass;

    assign last_step = ({1'b0, step} == (group_len(grp) - 5'd1));
    assign last_pass = (pass == PASS_W'(PASSES - 1));

    always_comb begin
        grp_n  = grp;
        step_n = step;
        pass_n = pass;
        if (tick) begin
            if (!last_step) begin
                step_n = step + STEP_W'(1);
            end else begin
                step_n = '0;
                if (!last_pass) begin
                    pass_n = pass + PASS_W'(1);
                end else begin
                    pass_n = '0;
                    unique case (grp)
                        GRP_BLINK: grp_n = GRP_SWAP;
                        GRP_SWAP:  grp_n = GRP_PAIR;
                        GRP_PAIR:  grp_n = GRP_CHASE;
                        GRP_CHASE: grp_n = GRP_BLINK;
                        default:   grp_n = GRP_BLINK;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            grp  <= GRP_BLINK;
            step <= '0;
            pass <= '0;
        end else begin
            grp  <= grp_n;
            step <= step_n;
            pass <= pass_n;
        end
    end
endmodule

// File: rtl/led_pattern_rom.sv
module led_pattern_rom
    import led_seq_pkg::*;
(
    input  grp_e              grp,
    input  logic [STEP_W-1:0] step,
    output logic [LED_W-1:0]  led
);
    always_comb begin
        unique case (grp)
            GRP_BLINK: led = step[0] ? 16'h0002 : 16'h0001;
            GRP_SWAP:  led = step[0] ? 16'h00FF : 16'hFF00;
            GRP_PAIR:  led = step[0] ? 16'h01C6 : 16'h3005;
            GRP_CHASE: begin
                unique case (step)
                    4'd0:    led = 16'h0307;
                    4'd1:    led = 16'h0008;
                    4'd2:    led = 16'h1208;
                    4'd3:    led = 16'h0008;
                    4'd4:    led = 16'h4307;
                    4'd5:    led = 16'h0008;
                    4'd6:    led = 16'h2208;
                    4'd7:    led = 16'h8008;
                    4'd8:    led = 16'h1307;
                    4'd9:    led = 16'h0008;
                    4'd10:   led = 16'h3208;
                    4'd11:   led = 16'h0008;
                    4'd12:   led = 16'h4F07;
                    4'd13:   led = 16'h0788;
                    4'd14:   led = 16'h2208;
                    4'd15:   led = 16'h8388;
                    default: led = 16'h0000;
                endcase
            end
            default: led = 16'h0000;
        endcase
    end
endmodule

// File: rtl/led_pattern_seq.sv
module led_pattern_seq
    import led_seq_pkg::*;
#(
    parameter int unsigned CLKS_PER_STEP = 50_000_000,
    parameter int unsigned PASSES        = 11
) (
    input  logic        clk,
    input  logic        rst,
    output logic [15:0] led_out,
    output logic [1:0]  mode_out
);
    localparam int unsigned PASS_W = (PASSES > 1) ? $clog2(PASSES) : 1;

    logic              step_tick;
    grp_e              grp;
    logic [STEP_W-1:0] step_idx;
    logic [PASS_W-1:0] pass_idx;

    led_step_timer #(
        .CLKS_PER_STEP(CLKS_PER_STEP)
    ) u_timer (
        .clk  (clk),
        .rst  (rst),
        .tick (step_tick)
    );

    led_seq_fsm #(
        .PASSES(PASSES),
        .PASS_W(PASS_W)
    ) u_fsm (
        .clk  (clk),
        .rst  (rst),
        .tick (step_tick),
        .grp  (grp),
        .step (step_idx),
        .pass (pass_idx)
    );

    led_pattern_rom u_rom (
        .grp  (grp),
        .step (step_idx),
        .led  (led_out)
    );

    assign mode_out = grp;
endmodule

// File: rtl/led_seq_checker.sv
module led_seq_checker
    import led_seq_pkg::*;
#(
    parameter int unsigned PASSES = 11,
    localparam int unsigned PASS_W = (PASSES > 1) ? $clog2(PASSES) : 1
) (
    input logic              clk,
    input logic              rst,
    input logic [15:0]       led_out,
    input logic [1:0]        mode_out,
    input logic              tick,
    input logic [STEP_W-1:0] step,
    input logic [PASS_W-1:0] pass
);
    logic group_end;
    assign group_end = tick
                    && ({1'b0, step} == (group_len(grp_e'(mode_out)) - 5'd1))
                    && (pass == PASS_W'(PASSES - 1));

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (led_out == 16'h0001 && mode_out == 2'd0));

    p_hold_between_ticks_r2: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(led_out));

    p_mode_stable_r7: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(mode_out));

    p_mode_advance_r7: assert property (@(posedge clk) disable iff (rst)
        group_end |=> (mode_out == $past(mode_out) + 2'd1));

    p_pass_range_r7: assert property (@(posedge clk) disable iff (rst)
        pass < PASS_W'(PASSES));

    p_wrap_to_first_r8: assert property (@(posedge clk) disable iff (rst)
        (group_end && mode_out == 2'd3) |=> (mode_out == 2'd0 && led_out == 16'h0001));

    p_step_in_group_r10: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, step} < group_len(grp_e'(mode_out))));
endmodule

bind led_pattern_seq led_seq_checker #(
    .PASSES(PASSES)
) u_led_seq_checker (
    .clk      (clk),
    .rst      (rst),
    .led_out  (led_out),
    .mode_out (mode_out),
    .tick     (step_tick),
    .step     (step_idx),
    .pass     (pass_idx)
);

// File: tb/led_pattern_seq_bench.sv
module led_pattern_seq_bench;
    localparam int N      = 4;
    localparam int PASSES = 11;

    // one pass of each group, groups laid end to end
    localparam logic [15:0] TBL [0:21] = '{
        16'h0001, 16'h0002,
        16'hFF00, 16'h00FF,
        16'h3005, 16'h01C6,
        16'h0307, 16'h0008, 16'h1208, 16'h0008, 16'h4307, 16'h0008, 16'h2208, 16'h8008,
        16'h1307, 16'h0008, 16'h3208, 16'h0008, 16'h4F07, 16'h0788, 16'h2208, 16'h8388
    };
    localparam int BASE [0:3] = '{0, 2, 4, 6};
    localparam int LEN  [0:3] = '{2, 2, 2, 16};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] led_out;
    logic [1:0]  mode_out;
    int          checks = 0;
    int          failures = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    led_pattern_seq #(.CLKS_PER_STEP(N), .PASSES(PASSES)) u_led_pattern_seq (
        .clk(clk), .rst(rst), .led_out(led_out), .mode_out(mode_out)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        // R1: reset state
        edges(3);
        chk("R1 led in reset", led_out, 16'h0001);
        chk("R1 mode in reset", {14'd0, mode_out}, 16'd0);
        rst = 1'b0;
        edges(N - 1);
        chk("R1 hold until first tick", led_out, 16'h0001);
        edges(1);
        chk("R2 change on tick edge", led_out, 16'h0002);
        edges(N - 1);
        chk("R2 held full interval", led_out, 16'h0002);

        // full walk of all groups and passes
        rst = 1'b1;
        edges(1);
        rst = 1'b0;
        edges(N / 2);
        for (int g = 0; g < 4; g++) begin
            for (int p = 0; p < PASSES; p++) begin
                for (int s = 0; s < LEN[g]; s++) begin
                    case (g)
                        0: chk("R3 group0 step", led_out, TBL[BASE[g] + s]);
                        1: chk("R4 group1 step", led_out, TBL[BASE[g] + s]);
                        2: chk("R5 group2 step", led_out, TBL[BASE[g] + s]);
                        default: chk("R6/R10 group3 step", led_out, TBL[BASE[g] + s]);
                    endcase
                    chk("R7 mode index", {14'd0, mode_out}, 16'(g));
                    edges(N);
                end
            end
        end
        chk("R8 wrap led", led_out, 16'h0001);
        chk("R8 wrap mode", {14'd0, mode_out}, 16'd0);

        // R9: reset in the middle of group 1
        edges(30 * N);
        chk("R7 mode mid run", {14'd0, mode_out}, 16'd1);
        rst = 1'b1;
        edges(1);
        chk("R9 led after mid-run reset", led_out, 16'h0001);
        chk("R9 mode after mid-run reset", {14'd0, mode_out}, 16'd0);
        edges(3 * N);
        chk("R9 reset held", led_out, 16'h0001);
        rst = 1'b0;
        edges(N - 1);
        chk("R9 prescaler restarted", led_out, 16'h0001);
        edges(1);
        chk("R9 first step after reset", led_out, 16'h0002);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule